// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block connects an on-chip requester to an external asynchronous static RAM of 32K bytes. The requester offers one transfer at a time: a 15-bit address, a direction flag and, for writes, a data byte. The block turns each transfer into a sequence of active-low chip-select, write-enable and output-enable levels. Every phase lasts a whole number of clock cycles, derived from nanosecond minimums and the clock period, so the memory's access, setup, pulse-width, recovery and bus-release limits hold.

The shared data bus is driven through three signals: an output byte, an output-enable for the pad driver, and the input byte seen on the pad. The block drives write data only while write-enable is low and output-enable is high, so the memory and the block never drive the bus together. Read data is captured on the edge that ends the access count and is announced by a single-cycle strobe. Between requests, chip-select stays high, which keeps the memory in its low-power standby state.

With the default timing (4 ns clock) the phases are as follows. A write is 1 setup cycle, then 3 cycles of write pulse, then 1 recovery cycle. A read is 1 setup cycle, then 3 cycles with output-enable low, then 3 cycles of bus release with chip-select high.

Top module: `sram_ctl`

## Requirements
- R1: During reset and whenever the block is idle, it holds `sram_cs_n`, `sram_we_n` and `sram_oe_n` high, keeps `dq_oe` low and holds `req_ready` high.
- R2: The block never drives the control pins into a read/write mix. A write has `sram_cs_n`=0, `sram_we_n`=0, `sram_oe_n`=1. A read has `sram_cs_n`=0, `sram_we_n`=1, `sram_oe_n`=0. `sram_we_n` and `sram_oe_n` are never low together.
- R3: `sram_addr` changes only while `sram_cs_n` is high. It stays constant for every cycle in which `sram_cs_n` is low.
- R4: Each write holds `sram_we_n` low for max(ceil(tWP/Tclk), ceil(tDW/Tclk)+1) cycles, which is 3 by default. `dq_oe` rises one cycle after `sram_we_n` falls and falls one cycle after `sram_we_n` rises. Data therefore overlaps the low pulse for 2 cycles. `dq_oe` is never high while `sram_oe_n` is low. The byte driven on `dq_out` is the accepted write data, and it is stored at the accepted address.
- R5: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is then low for exactly 5 cycles for a write and exactly 7 cycles for a read (default timing).
- R6: A read holds `sram_oe_n` low for 3 cycles (default timing). `rdata` takes the value on `dq_in` at the edge that ends that count. `rdata_valid` is high for exactly one cycle: the 5th cycle after acceptance, which is the first cycle with `sram_oe_n` high again.
- R7: After a read, `sram_cs_n` stays high for ceil(tHZ/Tclk) cycles (3 by default) before the block accepts new work. The data driver is never enabled within that window.
- R8: Changes on `req_addr`, `req_wdata` and `req_write` while `req_ready` is low have no effect on the transfer in progress.
- R9: `rdata` keeps its value until the next read completes. Writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rdata | output | 8 | Last read byte |
| rdata_valid | output | 1 | One-cycle strobe: `rdata` updated |
| sram_addr | output | 15 | Memory address pins |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| dq_out | output | 8 | Byte to drive on the data bus |
| dq_oe | output | 1 | Enable for the data bus driver |
| dq_in | input | 8 | Byte seen on the data bus |

## Verification
The hardest situation to provoke from the ports is a read that closely follows a write to the same address. This case shows whether data was committed at the end of the write overlap, and whether the bus was released and turned around cleanly. The stimulus runs a bench-side memory model that commits bytes only at the rising end of the write overlap. It mixes directed write-then-read pairs and extreme addresses with random operations on a narrow address window, so that such collisions happen often. During every busy period, the request fields are scrambled to show that they are ignored.

// File: rtl/sram_ctl_pkg.sv
// Shared types and helpers for the static RAM access sequencer.
// Assumes all timing inputs are non-negative nanosecond values.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WREC   = 3'd3,
        PH_RACC   = 3'd4,
        PH_RTURN  = 3'd5
    } phase_t;

    // Round a nanosecond minimum up to whole clock cycles, never below floor_c.
    function automatic int ns2cyc(input int ns, input int clk_ns, input int floor_c);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < floor_c) ? floor_c : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one phase of the access sequence.
// A load sets the phase length minus one; done is high in the last cycle of the phase.
// Assumes load is asserted exactly on the edge that enters a new phase.
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Last cycle of the phase.
    always_comb begin
        done = (cnt_q == '0);
    end
endmodule

// File: rtl/sram_ctl_datapath.sv
// Address, write data and read data registers plus the data bus driver enable.
// The address is loaded only on acceptance, while chip select is still high.
// The driver enable follows the write-pulse phase by one cycle, so it turns on
// after write enable falls and turns off after write enable rises.
module sram_ctl_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              in_wpulse,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              drv_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    // Latch the request fields when a transfer is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Delay the driver enable one cycle behind the write pulse phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= 1'b0;
        end else begin
            drv_q <= in_wpulse;
        end
    end

    // Capture the bus at the end of the access count and raise a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) begin
                rdata_q <= dq_in;
            end
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        sram_addr   = addr_q;
        dq_out      = wdata_q;
        dq_oe       = drv_q;
        rdata       = rdata_q;
        rdata_valid = rvalid_q;
    end
endmodule

// File: rtl/sram_ctl.sv
// Static RAM access sequencer: one byte per request, cycle-counted control phases.
// Write: setup (CS low) -> write pulse (WE low, OE high) -> recovery (WE high, CS low).
// Read: setup (CS low) -> access (OE low) -> bus release (CS high).
// Assumes the requester holds req_valid and its fields until req_ready is seen high.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 4,
    parameter int T_AS_NS = 0,
    parameter int T_WP_NS = 10,
    parameter int T_DW_NS = 7,
    parameter int T_WR_NS = 0,
    parameter int T_WC_NS = 15,
    parameter int T_AA_NS = 15,
    parameter int T_OE_NS = 7,
    parameter int T_RC_NS = 15,
    parameter int T_HZ_NS = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);
    localparam int AS_CYC     = ns2cyc(T_AS_NS, CLK_NS, 1);
    localparam int WP_CYC     = ns2cyc(T_WP_NS, CLK_NS, 1);
    localparam int DW_CYC     = ns2cyc(T_DW_NS, CLK_NS, 1);
    localparam int WE_LOW_CYC = imax(WP_CYC, DW_CYC + 1);
    localparam int WR_CYC     = ns2cyc(T_WR_NS, CLK_NS, 1);
    localparam int WC_CYC     = ns2cyc(T_WC_NS, CLK_NS, 1);
    localparam int REC_CYC    = imax(WR_CYC, WC_CYC - AS_CYC - WE_LOW_CYC);
    localparam int AA_CYC     = ns2cyc(T_AA_NS, CLK_NS, 1);
    localparam int OE_CYC     = ns2cyc(T_OE_NS, CLK_NS, 1);
    localparam int RC_CYC     = ns2cyc(T_RC_NS, CLK_NS, 1);
    localparam int RD_CYC     = imax(imax(AA_CYC - AS_CYC, OE_CYC), imax(RC_CYC - AS_CYC, 1));
    localparam int TA_CYC     = ns2cyc(T_HZ_NS, CLK_NS, 1);
    localparam int MAX_CYC    = imax(imax(imax(AS_CYC, WE_LOW_CYC), imax(REC_CYC, RD_CYC)), TA_CYC);
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    phase_t           ph_q;
    phase_t           ph_d;
    logic             is_wr_q;
    logic             accept;
    logic             ph_done;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             cs_n_q;
    logic             we_n_q;
    logic             oe_n_q;

    // Pick the next phase and the length to load when a phase starts.
    always_comb begin
        ph_d     = ph_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    ph_d     = PH_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(AS_CYC - 1);
                end
            end
            PH_SETUP: begin
                if (ph_done) begin
                    tmr_load = 1'b1;
                    if (is_wr_q) begin
                        ph_d    = PH_WPULSE;
                        tmr_val = CNT_W'(WE_LOW_CYC - 1);
                    end else begin
                        ph_d    = PH_RACC;
                        tmr_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            PH_WPULSE: begin
                if (ph_done) begin
                    ph_d     = PH_WREC;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(REC_CYC - 1);
                end
            end
            PH_WREC: begin
                if (ph_done) begin
                    ph_d = PH_IDLE;
                end
            end
            PH_RACC: begin
                if (ph_done) begin
                    ph_d     = PH_RTURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TA_CYC - 1);
                end
            end
            PH_RTURN: begin
                if (ph_done) begin
                    ph_d = PH_IDLE;
                end
            end
            default: begin
                ph_d = PH_IDLE;
            end
        endcase
    end

    // Phase register and the latched direction of the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            is_wr_q <= 1'b0;
        end else begin
            ph_q <= ph_d;
            if (accept) begin
                is_wr_q <= req_write;
            end
        end
    end

    // Registered control pins, derived from the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            we_n_q <= 1'b1;
            oe_n_q <= 1'b1;
        end else begin
            cs_n_q <= !(ph_d == PH_SETUP || ph_d == PH_WPULSE ||
                        ph_d == PH_WREC  || ph_d == PH_RACC);
            we_n_q <= (ph_d != PH_WPULSE);
            oe_n_q <= (ph_d != PH_RACC);
        end
    end

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (ph_done)
    );

    sram_ctl_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .in_wpulse   (ph_q == PH_WPULSE),
        .capture     (ph_q == PH_RACC && ph_done),
        .dq_in       (dq_in),
        .sram_addr   (sram_addr),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

    // Expose pins and the ready flag.
    always_comb begin
        sram_cs_n = cs_n_q;
        sram_we_n = we_n_q;
        sram_oe_n = oe_n_q;
        req_ready = (ph_q == PH_IDLE);
    end
endmodule

// File: rtl/sram_ctl_checker.sv
// Protocol checker for the sequencer's memory-side and request-side pins.
// Assumes MIN_WE_LOW equals the write pulse length chosen by the top module.
module sram_ctl_checker #(
    parameter int ADDR_W     = 15,
    parameter int MIN_WE_LOW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rdata_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_cs_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              dq_oe
);
    int we_low_cnt;

    // Count consecutive cycles with write enable low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= 0;
        end else if (!sram_we_n) begin
            we_low_cnt <= we_low_cnt + 1;
        end else begin
            we_low_cnt <= 0;
        end
    end

    assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs_n && sram_we_n && sram_oe_n && !dq_oe));

    assert_no_mixed_controls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && !sram_cs_n));

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt == MIN_WE_LOW));

    assert_driver_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (sram_oe_n && !sram_cs_n));

    assert_driver_after_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (!sram_we_n && $past(!sram_we_n)));

    assert_ready_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_rvalid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);

    assert_rvalid_at_oe_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> $rose(sram_oe_n));
endmodule

bind sram_ctl sram_ctl_checker #(
    .ADDR_W     (ADDR_W),
    .MIN_WE_LOW (WE_LOW_CYC)
) u_sram_ctl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rdata_valid (rdata_valid),
    .sram_addr   (sram_addr),
    .sram_cs_n   (sram_cs_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .dq_oe       (dq_oe)
);

// File: tb/sram_ctl_test.sv
// Bench for sram_ctl: pin-level memory model, directed corners plus seeded random traffic.
module sram_ctl_test;
    // Expected cycle counts at a 4 ns clock, from the nanosecond minimums.
    localparam int EXP_WE_LOW = 3;  // max(ceil(10/4), ceil(7/4)+1)
    localparam int EXP_OVL    = 2;  // driver overlap with WE low
    localparam int EXP_OE_LOW = 3;  // max(ceil(15/4)-1, ceil(7/4), ceil(15/4)-1)
    localparam int EXP_W_BUSY = 5;  // 1 setup + 3 pulse + 1 recovery
    localparam int EXP_R_BUSY = 7;  // 1 setup + 3 access + 3 release
    localparam int EXP_RV_POS = 5;  // strobe cycle after acceptance
    localparam int EXP_TA     = 3;  // ceil(9/4)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_valid;
    logic [14:0] sram_addr;
    logic        sram_cs_n, sram_we_n, sram_oe_n;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic [7:0]  dq_in = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done_flag = 1'b0;

    logic [7:0] model_mem [int];
    logic [7:0] shadow    [int];
    logic [14:0] cur_a;
    logic [7:0]  cur_d;

    always #2 clk = ~clk;

    sram_ctl uut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rdata (rdata), .rdata_valid (rdata_valid),
        .sram_addr (sram_addr), .sram_cs_n (sram_cs_n), .sram_we_n (sram_we_n),
        .sram_oe_n (sram_oe_n), .dq_out (dq_out), .dq_oe (dq_oe), .dq_in (dq_in)
    );

    function automatic logic [7:0] fill_pat(input logic [14:0] a);
        return a[7:0] ^ {1'b1, a[14:8]} ^ 8'hA5;
    endfunction

    function automatic logic [7:0] exp_read(input logic [14:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : fill_pat(a);
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // Memory model and pin protocol monitor, sampled at falling edges.
    logic        p_cs = 1'b1, p_we = 1'b1, p_oe = 1'b1;
    logic [14:0] p_addr = '0;
    int          we_run = 0, ovl = 0, oe_run = 0, since_rd = 100;
    logic [7:0]  wl = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_cs_n && !p_cs && sram_addr != p_addr)
                check(1'b0, "R3 addr moved with CS low", sram_addr, p_addr);
            if (!sram_we_n && !sram_oe_n)
                check(1'b0, "R2 WE and OE both low", 0, 1);
            if (dq_oe && !sram_oe_n)
                check(1'b0, "R4 bus contention", 1, 0);
            if (dq_oe && since_rd < EXP_TA)
                check(1'b0, "R7 driver inside release window", since_rd, EXP_TA);
            if (!sram_we_n && dq_oe) begin
                ovl++;
                wl = dq_out;
            end
            if (!sram_we_n) begin
                we_run++;
            end else if (!p_we) begin
                check(we_run == EXP_WE_LOW, "R4 WE low width", we_run, EXP_WE_LOW);
                check(ovl == EXP_OVL, "R4 data overlap", ovl, EXP_OVL);
                check(p_addr == cur_a, "R4 write address", p_addr, cur_a);
                check(wl == cur_d, "R4 write data", wl, cur_d);
                if (ovl > 0) model_mem[int'(p_addr)] = wl;
                we_run = 0;
                ovl = 0;
            end
            if (!sram_oe_n) begin
                oe_run++;
            end else if (!p_oe) begin
                check(oe_run == EXP_OE_LOW, "R6 OE low width", oe_run, EXP_OE_LOW);
                oe_run = 0;
                since_rd = 0;
            end
            if (sram_oe_n && since_rd < 100) since_rd++;
            dq_in = (!sram_cs_n && sram_we_n && !sram_oe_n) ?
                    (model_mem.exists(int'(sram_addr)) ? model_mem[int'(sram_addr)] : fill_pat(sram_addr))
                    : 8'h00;
        end
        p_cs = sram_cs_n; p_we = sram_we_n; p_oe = sram_oe_n; p_addr = sram_addr;
    end

    // One transfer: offer, wait for acceptance, scramble fields while busy, check timing.
    task automatic do_req(input bit wr, input logic [14:0] a, input logic [7:0] d);
        int n;
        int rv_cnt;
        int rv_pos;
        logic [7:0] got;
        logic [7:0] prev_rdata;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        cur_a = a; cur_d = d;
        while (!req_ready) @(negedge clk);
        prev_rdata = rdata;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 15'($urandom);  // R8: scrambled while busy
        req_wdata = 8'($urandom);
        req_write = 1'($urandom);
        n = 0; rv_cnt = 0; rv_pos = 0; got = '0;
        while (!req_ready && n < 50) begin
            n++;
            if (rdata_valid) begin
                rv_cnt++; rv_pos = n; got = rdata;
            end
            if (!wr && n > EXP_RV_POS - 1 && !sram_cs_n)
                check(1'b0, "R7 CS low during release", n, EXP_RV_POS);
            @(negedge clk);
            req_addr = 15'($urandom);
        end
        if (wr) begin
            check(n == EXP_W_BUSY, "R5 write busy cycles", n, EXP_W_BUSY);
            check(rv_cnt == 0, "R9 strobe on write", rv_cnt, 0);
            check(rdata == prev_rdata, "R9 rdata held over write", rdata, prev_rdata);
            shadow[int'(a)] = d;
        end else begin
            check(n == EXP_R_BUSY, "R5 read busy cycles", n, EXP_R_BUSY);
            check(rv_cnt == 1, "R6 strobe count", rv_cnt, 1);
            check(rv_pos == EXP_RV_POS, "R6 strobe cycle", rv_pos, EXP_RV_POS);
            check(got == exp_read(a), "R6 read data", got, exp_read(a));
        end
        check(sram_cs_n && sram_we_n && sram_oe_n && !dq_oe, "R1 idle pins", 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check(sram_cs_n && sram_we_n && sram_oe_n && !dq_oe && req_ready,
              "R1 reset state", {sram_cs_n, sram_we_n, sram_oe_n, dq_oe, req_ready}, 5'b11101);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && sram_cs_n, "R1 after reset", req_ready, 1);

        // Directed corners: extreme addresses, read of untouched location, write then read.
        do_req(1'b1, 15'h0000, 8'h3C);
        do_req(1'b1, 15'h7FFF, 8'hC3);
        do_req(1'b0, 15'h0000, 8'h00);
        do_req(1'b0, 15'h7FFF, 8'h00);
        do_req(1'b0, 15'h1234, 8'h00);
        do_req(1'b1, 15'h1234, 8'h00);
        do_req(1'b0, 15'h1234, 8'h00);
        do_req(1'b1, 15'h1234, 8'hFF);
        do_req(1'b1, 15'h1234, 8'h5A);
        do_req(1'b0, 15'h1234, 8'h00);
        // R9: a write after a read leaves rdata unchanged (checked inside do_req).
        do_req(1'b1, 15'h0001, 8'h77);

        // Random traffic on a narrow window plus the full range.
        for (int i = 0; i < 300; i++) begin
            logic [14:0] a;
            a = ($urandom % 4 == 0) ? 15'($urandom) : 15'($urandom % 16);
            do_req(1'($urandom), a, 8'($urandom));
        end
        for (int i = 0; i < 16; i++) do_req(1'b0, 15'(i), 8'h00);

        repeat (5) @(negedge clk);
        summary();
    end
endmodule